// File: doc/BRIEF.md
# Supervisor Watchdog with Timed Reset Hold

This block watches a processor for signs of life. The processor must pull a strobe line from high to low at regular intervals. Each such falling edge starts a new timeout window. If the selected window elapses with no falling edge, the block drives reset to the processor. Once reset is driven, it is held for a fixed 250 ms. After that the block releases reset and starts a new window.

Time is counted in milliseconds. A prescaler turns a parameterised number of clock cycles into one millisecond. The same 250 ms hold also applies after the chip reset is released, and whenever the supply-good flag drops and comes back. The watchdog has no disable input. The strobe is sampled by a two-stage synchronizer, so a strobe pulse that covers at least two clock periods is always seen. With a fast clock this covers the shortest pulses a processor produces.

Top module: `wdog_supervisor`

## Requirements
- R1: Driving `rst_n` low puts `sys_rst` at 1 and `sys_rst_n` at 0 at once, without waiting for a clock edge.
- R2: After `rst_n` rises, reset stays asserted. It releases on the (250·CYC_PER_MS + 2)th rising clock edge. The two extra edges come from the internal reset release synchronizer.
- R3: The period select code sets the timeout: 2'b00 gives 150 ms, 2'b01 gives 610 ms, and 2'b10 and 2'b11 both give 1200 ms. When a window starts and no falling strobe edge arrives, `sys_rst` rises on the (period·CYC_PER_MS)th edge after the start.
- R4: A falling strobe edge restarts the window from zero while reset is released. It takes effect three rising edges after the low level is first sampled. Strobes that come more often than the period keep reset deasserted.
- R5: A strobe held steadily low, or steadily high, never restarts the window.
- R6: Strobe edges that occur while reset is asserted have no effect on the length of the reset hold.
- R7: `supply_ok` at 0 asserts reset at the next clock edge and freezes the hold count at zero. After `supply_ok` returns to 1, reset releases on the (250·CYC_PER_MS)th edge.
- R8: After a timeout, reset stays asserted for exactly 250·CYC_PER_MS cycles. It then releases and a new window starts from zero.
- R9: `sys_rst_n` is always the complement of `sys_rst`, and both come straight from flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. CYC_PER_MS cycles make one millisecond. |
| rst_n | input | 1 | Chip reset, active low. It asserts asynchronously and is released through a synchronizer. |
| period_sel | input | 2 | Timeout select: 00 = 150 ms, 01 = 610 ms, 1x = 1200 ms. |
| strobe | input | 1 | Keep-alive line from the processor. A falling edge restarts the window. |
| supply_ok | input | 1 | High while the supply is within tolerance. |
| sys_rst | output | 1 | Processor reset, active high. |
| sys_rst_n | output | 1 | Processor reset, active low. |

## Verification
The hardest case to reach is a strobe edge landing inside the reset hold while the hold count is still running. An ignored edge only shows up as the absence of a change in the hold length. The stimulus therefore toggles the strobe several times early in every post-timeout hold, and also changes the select code and the resting strobe level there. It then measures the exact hold length and the exact length of the following timeout window. Running each window with a steady high or steady low strobe also shows that levels alone never restart the count.

// File: rtl/wd_pkg.sv
`timescale 1ns/1ps
package wd_pkg;
  typedef enum logic {
    WD_HOLD = 1'b0,
    WD_RUN  = 1'b1
  } wd_state_e;
endpackage

// File: rtl/wd_strobe_sync.sv
`timescale 1ns/1ps
module wd_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic fall_o
);
  localparam int TOP = SYNC_STAGES;

  logic [TOP:0] sh_q;
  logic [TOP:0] sh_d;

  always_comb begin
    sh_d = {sh_q[TOP-1:0], strobe_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // Oldest synchronized sample high, next one low: one falling edge.
  assign fall_o = sh_q[TOP] & ~sh_q[TOP-1];

  // R4: one falling edge is reported for exactly one cycle.
  p_fall_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/wd_ms_prescale.sv
`timescale 1ns/1ps
module wd_ms_prescale #(
  parameter int CYC_PER_MS = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (CYC_PER_MS > 2) ? $clog2(CYC_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign tick_o = (cnt_q == LAST);

  always_comb begin
    if (clr_i || tick_o) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: every millisecond tick is followed by a fresh prescale count.
  p_tick_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/wd_ctrl.sv
`timescale 1ns/1ps
module wd_ctrl
  import wd_pkg::*;
#(
  parameter int SHORT_MS = 150,
  parameter int MID_MS   = 610,
  parameter int LONG_MS  = 1200,
  parameter int HOLD_MS  = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  input  logic       supply_ok_i,
  input  logic       fall_i,
  input  logic       tick_i,
  output logic       clr_o,
  output logic       rst_o,
  output logic       rst_n_o
);
  localparam int MAX_MS = (LONG_MS > HOLD_MS) ? LONG_MS : HOLD_MS;
  localparam int MW     = $clog2(MAX_MS + 1);
  localparam logic [MW-1:0] HOLD_END = MW'(HOLD_MS - 1);

  wd_state_e     state_q, state_d;
  logic [MW-1:0] ms_q, ms_d, lim_end;
  logic          ms_en;

  // Select decode: 00 shortest, 01 middle, 1x longest.
  always_comb begin
    case (sel_i)
      2'b00:   lim_end = MW'(SHORT_MS - 1);
      2'b01:   lim_end = MW'(MID_MS - 1);
      default: lim_end = MW'(LONG_MS - 1);
    endcase
  end

  always_comb begin
    state_d = state_q;
    ms_d    = ms_q;
    clr_o   = 1'b0;
    if (!supply_ok_i) begin
      state_d = WD_HOLD;
      ms_d    = '0;
      clr_o   = 1'b1;
    end else if (state_q == WD_HOLD) begin
      if (tick_i) begin
        if (ms_q >= HOLD_END) begin
          state_d = WD_RUN;
          ms_d    = '0;
          clr_o   = 1'b1;
        end else begin
          ms_d = ms_q + 1'b1;
        end
      end
    end else begin
      if (fall_i) begin
        ms_d  = '0;
        clr_o = 1'b1;
      end else if (tick_i) begin
        if (ms_q >= lim_end) begin
          state_d = WD_HOLD;
          ms_d    = '0;
          clr_o   = 1'b1;
        end else begin
          ms_d = ms_q + 1'b1;
        end
      end
    end
  end

  assign ms_en = tick_i | clr_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WD_HOLD;
      ms_q    <= '0;
      rst_o   <= 1'b1;
      rst_n_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ms_en) ms_q <= ms_d;
      rst_o   <= (state_d == WD_HOLD);
      rst_n_o <= (state_d != WD_HOLD);
    end
  end

  // R2: reset only releases once the full hold count has been reached.
  p_hold_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_o) |-> ($past(ms_q) == HOLD_END && $past(state_q) == WD_HOLD));

  // R3: a timeout only fires once the selected window is used up.
  p_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_o) && $past(supply_ok_i)) |-> ($past(ms_q) >= $past(lim_end)));

  // R4: a strobe edge while running clears the count and keeps reset off.
  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_RUN && supply_ok_i && fall_i) |=> (ms_q == '0 && !rst_o));

  // R6: a strobe edge during the hold leaves the hold count untouched.
  p_hold_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WD_HOLD && supply_ok_i && fall_i && !tick_i) |=> (ms_q == $past(ms_q)));

  // R7: a supply fault asserts reset and parks the count at zero.
  p_supply_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |=> (rst_o && ms_q == '0));
endmodule

// File: rtl/wdog_supervisor.sv
`timescale 1ns/1ps
module wdog_supervisor #(
  parameter int CYC_PER_MS = 100000,
  parameter int SHORT_MS   = 150,
  parameter int MID_MS     = 610,
  parameter int LONG_MS    = 1200,
  parameter int HOLD_MS    = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] period_sel,
  input  logic       strobe,
  input  logic       supply_ok,
  output logic       sys_rst,
  output logic       sys_rst_n
);
  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       fall;
  logic       tick;
  logic       clr;

  // Asynchronous assertion, synchronous release of the internal reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  wd_strobe_sync #(.SYNC_STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .strobe_i (strobe),
    .fall_o   (fall)
  );

  wd_ms_prescale #(.CYC_PER_MS(CYC_PER_MS)) u_pre (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (clr),
    .tick_o (tick)
  );

  wd_ctrl #(
    .SHORT_MS (SHORT_MS),
    .MID_MS   (MID_MS),
    .LONG_MS  (LONG_MS),
    .HOLD_MS  (HOLD_MS)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sel_i       (period_sel),
    .supply_ok_i (supply_ok),
    .fall_i      (fall),
    .tick_i      (tick),
    .clr_o       (clr),
    .rst_o       (sys_rst),
    .rst_n_o     (sys_rst_n)
  );

  // R9: the two reset outputs never agree.
  p_outputs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst != sys_rst_n);
endmodule

// File: tb/sim_wdog_supervisor.sv
`timescale 1ns/1ps
module sim_wdog_supervisor;
  localparam int CPM = 4;
  localparam int SH  = 150;
  localparam int MD  = 610;
  localparam int LG  = 1200;
  localparam int HD  = 250;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] sel;
  logic       strobe;
  logic       supply_ok;
  logic       sys_rst;
  logic       sys_rst_n;

  always #2.5 clk = ~clk;

  wdog_supervisor #(
    .CYC_PER_MS(CPM), .SHORT_MS(SH), .MID_MS(MD), .LONG_MS(LG), .HOLD_MS(HD)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .period_sel(sel), .strobe(strobe),
    .supply_ok(supply_ok), .sys_rst(sys_rst), .sys_rst_n(sys_rst_n)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // Behavioural reference: elapsed cycles since the last restart.
  bit m_hold = 1'b1;
  int m_e    = 0;
  int m_rel  = 0;
  bit m_hist[$] = '{1'b0, 1'b0, 1'b0};

  function automatic int lim_cycles(logic [1:0] s);
    if (s == 2'b00)      return SH * CPM;
    else if (s == 2'b01) return MD * CPM;
    else                 return LG * CPM;
  endfunction

  always @(posedge clk) begin
    bit f;
    if (!rst_n) begin
      m_rel = 0; m_hold = 1'b1; m_e = 0; m_hist = '{1'b0, 1'b0, 1'b0};
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      f = m_hist[m_hist.size()-3] && !m_hist[m_hist.size()-2];
      if (!supply_ok) begin
        m_hold = 1'b1; m_e = 0;
      end else if (m_hold) begin
        m_e++;
        if (m_e >= HD * CPM) begin m_hold = 1'b0; m_e = 0; end
      end else if (f) begin
        m_e = 0;
      end else begin
        m_e++;
        if (m_e >= lim_cycles(sel)) begin m_hold = 1'b1; m_e = 0; end
      end
      m_hist.push_back(strobe);
      void'(m_hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (sys_rst !== m_hold || sys_rst_n !== !m_hold) begin
        n_bad++;
        $display("FAIL %s/R9 at %0t: got rst=%b rst_n=%b expected rst=%b rst_n=%b",
                 cur_req, $time, sys_rst, sys_rst_n, m_hold, !m_hold);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 1;
    forever begin
      @(negedge clk);
      if (sys_rst !== lvl) break;
      n++;
    end
  endtask

  // Measure a hold while toggling the strobe (R6), then set up the next window.
  task automatic hold_phase(input logic [1:0] nsel, input logic nstb, output int n);
    n = 1;
    forever begin
      @(negedge clk);
      if (sys_rst !== 1'b1) break;
      n++;
      #1;
      if (n < 40 && (n % 5) == 0) strobe = ~strobe;
      if (n == 40) begin strobe = nstb; sel = nsel; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL %s: watchdog expired, got 0 expected 1 finished run", cur_req);
      finish_up();
    end
  end

  initial begin
    int n;
    bit saw;
    logic [1:0] sels [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
    logic       stbs [4] = '{1'b1, 1'b0, 1'b1, 1'b0};
    int         lims [4] = '{SH, MD, LG, LG};

    rst_n = 1'b0; strobe = 1'b1; supply_ok = 1'b1; sel = 2'b00;
    step(4);
    cur_req = "R1";
    chk("R1 reset state sys_rst", sys_rst, 1);
    chk("R1 reset state sys_rst_n", sys_rst_n, 0);

    // R2: hold after chip reset release, including the release synchronizer.
    rst_n = 1'b1;
    cur_req = "R2";
    n = 0;
    forever begin @(negedge clk); if (!sys_rst) break; n++; end
    chk("R2 power-up hold length", n, HD * CPM + 1);

    // R4: strobes faster than the 150 ms window keep reset off.
    cur_req = "R4";
    saw = 1'b0;
    repeat (8) begin
      #1 strobe = 1'b0;
      repeat (4)   begin @(negedge clk); if (sys_rst) saw = 1'b1; end
      #1 strobe = 1'b1;
      repeat (496) begin @(negedge clk); if (sys_rst) saw = 1'b1; end
    end
    chk("R4 keep-alive strobes hold reset off", saw, 0);

    // Stop strobing: wait for the timeout.
    cur_req = "R3";
    forever begin @(negedge clk); if (sys_rst) break; end

    for (int k = 0; k < 4; k++) begin
      cur_req = "R6";
      hold_phase(sels[k], stbs[k], n);
      chk("R6/R8 hold length with strobes during reset", n, HD * CPM);
      cur_req = (stbs[k] == 1'b0) ? "R5" : "R3";
      run_len(1'b0, n);
      chk((stbs[k] == 1'b0) ? "R5 steady-low strobe window" : "R3 window for select code",
          n, lims[k] * CPM);
    end

    cur_req = "R8";
    run_len(1'b1, n);
    chk("R8 hold after timeout", n, HD * CPM);

    // R7: supply fault.
    step(20);
    cur_req = "R7";
    supply_ok = 1'b0;
    @(negedge clk);
    chk("R7 reset on supply fault", sys_rst, 1);
    #1 strobe = 1'b0;
    step(10);
    strobe = 1'b1;
    step(20);
    supply_ok = 1'b0;
    step(1);
    supply_ok = 1'b1;
    n = 0;
    forever begin @(negedge clk); if (!sys_rst) break; n++; end
    chk("R7 hold after supply returns", n, HD * CPM - 1);

    // R1: asynchronous assertion mid-run.
    step(50);
    cur_req = "R1";
    rst_n = 1'b0;
    #1;
    chk("R1 async assert sys_rst", sys_rst, 1);
    chk("R1 async assert sys_rst_n", sys_rst_n, 0);
    step(3);
    rst_n = 1'b1;
    step(5);
    finish_up();
  end
endmodule